// File: doc/BRIEF.md
# Poll-Reply Radio Link Sequencer

This controller runs a half-duplex packet radio through a register-command port. In each poll period it loads and sends a two-byte request packet. It then polls the radio's interrupt flag register until the transmit-done flag appears. Next it retunes the radio to the receive channel, arms continuous receive and polls for one reply. After that it returns the radio to sleep and waits for the next period. All timeouts come from a millisecond tick and use wrap-safe subtraction on a free-running counter.

Each register access is one command to an external transfer engine. The command fields are write flag, 7-bit register address and write byte. The sequencer holds `cmd_valid` and all fields stable until the engine pulses `cmd_done`. On a read, the engine returns the register byte on `cmd_rdata` in that same cycle. The engine applies back-pressure by delaying `cmd_done`; the sequencer never drops or changes a pending command. When a reply arrives, the sequencer reports it with a one-cycle pulse. A good packet pulses `evt_reply`, which also triggers the reply decoder. A packet that fails its payload CRC pulses `evt_crc_err` instead.

Top module: `radio_poll_seq`

## Requirements
- R1: While reset is held, `cmd_valid`, `evt_reply` and `evt_crc_err` are low. After reset, the first two commands write the mode register (address 0x01) with 0x00 and then with 0x80.
- R2: A transmit cycle issues exactly these writes, in this order:
  - 0x01←0x81 (standby)
  - 0x0D←0x80 (buffer pointer)
  - 0x00←0x55, then 0x00←0x0F (payload)
  - 0x09←power byte, then 0x4D←0x84 (power)
  - 0x06, 0x07, 0x08 ← the three bytes of `TX_FREQ`, high byte first
  - 0x12←0xFF (clear flags)
  - 0x22←0x02 (payload length)
  - 0x01←0x83 (transmit)
- R3: The power byte is 0x80 OR the value of `tx_power` when that value is 15 or less. A larger value is written as 0x8F.
- R4: While `cmd_valid` is high and `cmd_done` is low, all command fields stay stable. In the cycle after `cmd_done`, `cmd_valid` is low.
- R5: After a transmit cycle, the sequencer polls with reads of the flag register 0x12. Once a read returns bit 3 (transmit done) set, it issues exactly these writes, in order:
  - 0x0F←0x00 (receive base)
  - 0x06, 0x07, 0x08 ← the three bytes of `RX_FREQ`, high byte first
  - 0x12←0xFF (clear flags)
  - 0x22←0x06 (payload length)
  - 0x01←0x85 (continuous receive)
- R6: A transmit poll read can complete without bit 3 set when more than `TX_TIMEOUT_MS` ticks have elapsed since the transmit cycle began. In that case the sequencer writes 0x01←0x80 (sleep) and does not set up receive. At exactly `TX_TIMEOUT_MS` it polls again.
- R7: A receive poll read can return bit 6 set with bit 5 clear. In that case `evt_reply` pulses for one cycle, in the cycle after `cmd_done`, and the sleep write 0x01←0x80 follows.
- R8: A receive poll read can return bits 6 and 5 both set. In that case `evt_crc_err` pulses for one cycle instead of `evt_reply`, and the sleep write follows.
- R9: A receive poll read can complete without bit 6 set when more than `RX_WINDOW_MS` ticks have passed since the receive arm write completed. In that case the sleep write follows and no event pulses. At exactly `RX_WINDOW_MS` it polls again.
- R10: After the sleep write, no command is issued until more than `PERIOD_MS` ticks have elapsed since the previous transmit cycle began. The next transmit cycle then starts.
- R11: During transmit polling, flag bits other than bit 3 have no effect. During receive polling, bits other than 6 have no effect, and bit 5 matters only when bit 6 is set. In each case the next command is another flag read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per elapsed millisecond |
| tx_power | input | 5 | Requested transmit power step, sampled when the power write is launched |
| cmd_valid | output | 1 | Register command pending |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | 7 | Register address |
| cmd_wdata | output | 8 | Byte to write |
| cmd_done | input | 1 | Transfer engine finished the pending command |
| cmd_rdata | input | 8 | Byte read, valid with `cmd_done` |
| evt_reply | output | 1 | Good reply received; starts the reply decoder |
| evt_crc_err | output | 1 | Reply received with payload CRC error |

## Verification
Timing of results:
- A new command appears two clock edges after the edge that accepts `cmd_done`: one edge clears `cmd_valid` and the next raises it.
- A reply event is registered on the edge that accepts the completing read, so it is visible in the following cycle.
- A period expiry becomes visible one edge after the counting tick. The state changes on the next edge, and `cmd_valid` rises on the edge after that.

How the bench keeps to this timing:
- It drives the millisecond ticks itself while a command is held open, so every elapsed-time comparison is exact, including the boundaries at the limits.
- It samples on falling edges. It checks events in the cycle after each completion.
- It holds the period boundary one tick short for several cycles before releasing it.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_TX_START,
    ST_TX_WAIT,
    ST_RX_SETUP,
    ST_RX_WAIT,
    ST_SLEEP_CMD,
    ST_SLEEP
  } seq_state_e;

  typedef struct packed {
    logic       wr;
    logic [6:0] addr;
    logic [7:0] data;
    logic       last;
  } reg_cmd_t;

  // radio register addresses decoded by the radio itself
  localparam logic [6:0] A_BUF     = 7'h00;
  localparam logic [6:0] A_MODE    = 7'h01;
  localparam logic [6:0] A_FRQ_HI  = 7'h06;
  localparam logic [6:0] A_FRQ_MD  = 7'h07;
  localparam logic [6:0] A_FRQ_LO  = 7'h08;
  localparam logic [6:0] A_PWR     = 7'h09;
  localparam logic [6:0] A_BUF_PTR = 7'h0D;
  localparam logic [6:0] A_RX_BASE = 7'h0F;
  localparam logic [6:0] A_FLAGS   = 7'h12;
  localparam logic [6:0] A_LEN     = 7'h22;
  localparam logic [6:0] A_PWR_DAC = 7'h4D;

  localparam logic [2:0] M_SLEEP   = 3'b000;
  localparam logic [2:0] M_STANDBY = 3'b001;
  localparam logic [2:0] M_TX      = 3'b011;
  localparam logic [2:0] M_RX_CONT = 3'b101;
  localparam logic [2:0] M_RX_ONE  = 3'b110;

  localparam int FLG_TXDONE = 3;
  localparam int FLG_CRCBAD = 5;
  localparam int FLG_RXDONE = 6;

  localparam logic [7:0] REQ_BYTE0  = 8'h55;
  localparam logic [7:0] REQ_BYTE1  = 8'h0F;
  localparam logic [7:0] TX_LEN     = 8'h02;
  localparam logic [7:0] RX_LEN     = 8'h06;
  localparam logic [7:0] TX_BUF_LOC = 8'h80;
  localparam logic [7:0] DAC_NORMAL = 8'h84;

  function automatic logic [7:0] mode_byte(input logic [2:0] code);
    return {5'b10000, code};
  endfunction

endpackage

// File: rtl/rps_clock.sv
module rps_clock #(
  parameter int MS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  output logic [MS_W-1:0] now
);
  always_ff @(posedge clk) begin
    if (!rst_n)    now <= '0;
    else if (tick) now <= now + 1'b1;
  end
endmodule

// File: rtl/rps_window.sv
module rps_window #(
  parameter int          MS_W  = 32,
  parameter int unsigned LIMIT = 100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MS_W-1:0] now,
  input  logic            arm,
  output logic            expired
);
  localparam logic [MS_W-1:0] LIM = MS_W'(LIMIT);

  logic [MS_W-1:0] mark;
  logic [MS_W-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (!rst_n)   mark <= '0;
    else if (arm) mark <= now;
  end

  // modular difference stays correct across counter wrap
  assign elapsed = now - mark;
  assign expired = elapsed > LIM;
endmodule

// File: rtl/rps_script.sv
module rps_script
  import rps_pkg::*;
#(
  parameter logic [23:0] TX_FREQ = 24'hD90000,
  parameter logic [23:0] RX_FREQ = 24'hD94000
) (
  input  seq_state_e state,
  input  logic [3:0] step,
  input  logic [4:0] tx_power,
  output reg_cmd_t   cmd
);
  logic [3:0] pwr;
  assign pwr = (tx_power > 5'd15) ? 4'hF : tx_power[3:0];

  always_comb begin
    cmd = '{wr: 1'b1, addr: A_MODE, data: mode_byte(M_SLEEP), last: 1'b1};
    unique case (state)
      ST_INIT: begin
        cmd.data = (step == 4'd0) ? 8'h00 : mode_byte(M_SLEEP);
        cmd.last = (step != 4'd0);
      end
      ST_TX_START: begin
        cmd.last = (step == 4'd11);
        case (step)
          4'd0:    begin cmd.addr = A_MODE;    cmd.data = mode_byte(M_STANDBY); end
          4'd1:    begin cmd.addr = A_BUF_PTR; cmd.data = TX_BUF_LOC; end
          4'd2:    begin cmd.addr = A_BUF;     cmd.data = REQ_BYTE0; end
          4'd3:    begin cmd.addr = A_BUF;     cmd.data = REQ_BYTE1; end
          4'd4:    begin cmd.addr = A_PWR;     cmd.data = {4'h8, pwr}; end
          4'd5:    begin cmd.addr = A_PWR_DAC; cmd.data = DAC_NORMAL; end
          4'd6:    begin cmd.addr = A_FRQ_HI;  cmd.data = TX_FREQ[23:16]; end
          4'd7:    begin cmd.addr = A_FRQ_MD;  cmd.data = TX_FREQ[15:8]; end
          4'd8:    begin cmd.addr = A_FRQ_LO;  cmd.data = TX_FREQ[7:0]; end
          4'd9:    begin cmd.addr = A_FLAGS;   cmd.data = 8'hFF; end
          4'd10:   begin cmd.addr = A_LEN;     cmd.data = TX_LEN; end
          default: begin cmd.addr = A_MODE;    cmd.data = mode_byte(M_TX); end
        endcase
      end
      ST_RX_SETUP: begin
        cmd.last = (step == 4'd6);
        case (step)
          4'd0:    begin cmd.addr = A_RX_BASE; cmd.data = 8'h00; end
          4'd1:    begin cmd.addr = A_FRQ_HI;  cmd.data = RX_FREQ[23:16]; end
          4'd2:    begin cmd.addr = A_FRQ_MD;  cmd.data = RX_FREQ[15:8]; end
          4'd3:    begin cmd.addr = A_FRQ_LO;  cmd.data = RX_FREQ[7:0]; end
          4'd4:    begin cmd.addr = A_FLAGS;   cmd.data = 8'hFF; end
          4'd5:    begin cmd.addr = A_LEN;     cmd.data = RX_LEN; end
          default: begin cmd.addr = A_MODE;    cmd.data = mode_byte(M_RX_CONT); end
        endcase
      end
      ST_TX_WAIT, ST_RX_WAIT: begin
        cmd.wr   = 1'b0;
        cmd.addr = A_FLAGS;
        cmd.data = 8'h00;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/radio_poll_seq.sv
module radio_poll_seq
  import rps_pkg::*;
#(
  parameter int          MS_W          = 32,
  parameter int unsigned TX_TIMEOUT_MS = 200,
  parameter int unsigned RX_WINDOW_MS  = 700,
  parameter int unsigned PERIOD_MS     = 1000,
  parameter logic [23:0] TX_FREQ       = 24'hD90000,
  parameter logic [23:0] RX_FREQ       = 24'hD94000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic [4:0] tx_power,
  output logic       cmd_valid,
  output logic       cmd_write,
  output logic [6:0] cmd_addr,
  output logic [7:0] cmd_wdata,
  input  logic       cmd_done,
  input  logic [7:0] cmd_rdata,
  output logic       evt_reply,
  output logic       evt_crc_err
);
  seq_state_e      state;
  logic [3:0]      step;
  reg_cmd_t        scr;
  logic [MS_W-1:0] now_ms;
  logic            fin, arm_tx, arm_rx;
  logic            tx_late, next_due, rx_over;

  rps_clock #(.MS_W(MS_W)) u_clock (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .now(now_ms)
  );

  rps_script #(.TX_FREQ(TX_FREQ), .RX_FREQ(RX_FREQ)) u_script (
    .state(state), .step(step), .tx_power(tx_power), .cmd(scr)
  );

  assign fin    = cmd_valid && cmd_done;
  assign arm_tx = (fin && state == ST_INIT && scr.last) ||
                  (!cmd_valid && state == ST_SLEEP && next_due);
  assign arm_rx = fin && state == ST_RX_SETUP && scr.last;

  rps_window #(.MS_W(MS_W), .LIMIT(TX_TIMEOUT_MS)) u_tx_win (
    .clk(clk), .rst_n(rst_n), .now(now_ms), .arm(arm_tx), .expired(tx_late)
  );
  rps_window #(.MS_W(MS_W), .LIMIT(PERIOD_MS)) u_period (
    .clk(clk), .rst_n(rst_n), .now(now_ms), .arm(arm_tx), .expired(next_due)
  );
  rps_window #(.MS_W(MS_W), .LIMIT(RX_WINDOW_MS)) u_rx_win (
    .clk(clk), .rst_n(rst_n), .now(now_ms), .arm(arm_rx), .expired(rx_over)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_INIT;
      step        <= '0;
      cmd_valid   <= 1'b0;
      cmd_write   <= 1'b0;
      cmd_addr    <= '0;
      cmd_wdata   <= '0;
      evt_reply   <= 1'b0;
      evt_crc_err <= 1'b0;
    end else begin
      evt_reply   <= 1'b0;
      evt_crc_err <= 1'b0;
      if (!cmd_valid) begin
        if (state == ST_SLEEP) begin
          if (next_due) begin
            state <= ST_TX_START;
            step  <= '0;
          end
        end else begin
          cmd_valid <= 1'b1;
          cmd_write <= scr.wr;
          cmd_addr  <= scr.addr;
          cmd_wdata <= scr.data;
        end
      end else if (cmd_done) begin
        cmd_valid <= 1'b0;
        unique case (state)
          ST_INIT, ST_TX_START, ST_RX_SETUP, ST_SLEEP_CMD: begin
            if (scr.last) begin
              step <= '0;
              case (state)
                ST_INIT:     state <= ST_TX_START;
                ST_TX_START: state <= ST_TX_WAIT;
                ST_RX_SETUP: state <= ST_RX_WAIT;
                default:     state <= ST_SLEEP;
              endcase
            end else begin
              step <= step + 4'd1;
            end
          end
          ST_TX_WAIT: begin
            if (cmd_rdata[FLG_TXDONE]) begin
              state <= ST_RX_SETUP;
              step  <= '0;
            end else if (tx_late) begin
              state <= ST_SLEEP_CMD;
            end
          end
          ST_RX_WAIT: begin
            if (cmd_rdata[FLG_RXDONE]) begin
              if (cmd_rdata[FLG_CRCBAD]) evt_crc_err <= 1'b1;
              else                       evt_reply   <= 1'b1;
              state <= ST_SLEEP_CMD;
            end else if (rx_over) begin
              state <= ST_SLEEP_CMD;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rps_checks.sv
module rps_checks
  import rps_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_write,
  input logic [6:0] cmd_addr,
  input logic [7:0] cmd_wdata,
  input logic       cmd_done,
  input logic [7:0] cmd_rdata,
  input logic       evt_reply,
  input logic       evt_crc_err
);
  // R4
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_write) &&
                               $stable(cmd_addr) && $stable(cmd_wdata));

  // R4
  cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_done |=> !cmd_valid);

  // R3
  pwr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_write && cmd_addr == A_PWR |-> cmd_wdata[7:4] == 4'h8);

  // R7
  reply_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_reply |-> $past(cmd_valid && cmd_done && !cmd_write && cmd_addr == A_FLAGS &&
                        cmd_rdata[FLG_RXDONE] && !cmd_rdata[FLG_CRCBAD]));

  // R8
  crc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_crc_err |-> $past(cmd_valid && cmd_done && !cmd_write && cmd_addr == A_FLAGS &&
                          cmd_rdata[FLG_RXDONE] && cmd_rdata[FLG_CRCBAD]));

  // R7
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_reply && evt_crc_err));

  // R7
  evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_reply |=> !evt_reply);
endmodule

bind radio_poll_seq rps_checks u_checks (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_done(cmd_done),
  .cmd_rdata(cmd_rdata), .evt_reply(evt_reply), .evt_crc_err(evt_crc_err)
);

// File: tb/radio_poll_seq_test.sv
`timescale 1ns/1ps
module radio_poll_seq_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ms_tick;
  logic [4:0] tx_power;
  logic       cmd_valid, cmd_write, cmd_done;
  logic [6:0] cmd_addr;
  logic [7:0] cmd_wdata, cmd_rdata;
  logic       evt_reply, evt_crc_err;

  always #2 clk = ~clk;

  radio_poll_seq uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .tx_power(tx_power),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
    .evt_reply(evt_reply), .evt_crc_err(evt_crc_err)
  );

  typedef struct packed {
    logic        wr;
    logic [6:0]  addr;
    logic [7:0]  data;
    logic [31:0] pre;
    logic [31:0] adv;
    logic [1:0]  evt;
    logic [4:0]  pwr;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    total = 0;
  int    bad   = 0;
  bit    ended = 0;
  logic [4:0] cur_pwr;

  localparam logic [23:0] TXF = 24'hD90000;
  localparam logic [23:0] RXF = 24'hD94000;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic wr, input logic [6:0] a, input logic [7:0] d,
                      input int pre, input int adv, input int evt, input string tag);
    exp_t it;
    it.wr = wr; it.addr = a; it.data = d; it.pre = pre; it.adv = adv;
    it.evt = 2'(evt); it.pwr = cur_pwr;
    expq.push_back(it);
    tagq.push_back(tag);
  endtask

  task automatic push_tx(input int pre, input logic [7:0] pbyte);
    push(1, 7'h01, 8'h81, pre, 0, 0, "R2");
    push(1, 7'h0D, 8'h80, 0, 0, 0, "R2");
    push(1, 7'h00, 8'h55, 0, 0, 0, "R2");
    push(1, 7'h00, 8'h0F, 0, 0, 0, "R2");
    push(1, 7'h09, pbyte, 0, 0, 0, "R3");
    push(1, 7'h4D, 8'h84, 0, 0, 0, "R2");
    push(1, 7'h06, TXF[23:16], 0, 0, 0, "R2");
    push(1, 7'h07, TXF[15:8], 0, 0, 0, "R2");
    push(1, 7'h08, TXF[7:0], 0, 0, 0, "R2");
    push(1, 7'h12, 8'hFF, 0, 0, 0, "R2");
    push(1, 7'h22, 8'h02, 0, 0, 0, "R2");
    push(1, 7'h01, 8'h83, 0, 0, 0, "R2");
  endtask

  task automatic push_rx();
    push(1, 7'h0F, 8'h00, 0, 0, 0, "R5");
    push(1, 7'h06, RXF[23:16], 0, 0, 0, "R5");
    push(1, 7'h07, RXF[15:8], 0, 0, 0, "R5");
    push(1, 7'h08, RXF[7:0], 0, 0, 0, "R5");
    push(1, 7'h12, 8'hFF, 0, 0, 0, "R5");
    push(1, 7'h22, 8'h06, 0, 0, 0, "R5");
    push(1, 7'h01, 8'h85, 0, 0, 0, "R5");
  endtask

  // driver: builds the expected command stream with engine responses
  task automatic build();
    cur_pwr = 5'd9;
    push(1, 7'h01, 8'h00, 0, 0, 0, "R1");
    push(1, 7'h01, 8'h80, 0, 0, 0, "R1");
    // period 1: clean reply, ms mark 0
    push_tx(0, 8'h89);
    push(0, 7'h12, 8'h00, 0, 10, 0, "R5");
    push(0, 7'h12, 8'h40, 0, 0, 0, "R11");
    push(0, 7'h12, 8'h08, 0, 5, 0, "R5");
    push_rx();
    push(0, 7'h12, 8'h08, 0, 100, 0, "R11");
    push(0, 7'h12, 8'h40, 0, 0, 1, "R7");
    push(1, 7'h01, 8'h80, 0, 0, 0, "R7");
    // period 2: transmit never completes, mark 1001
    cur_pwr = 5'd20;
    push_tx(886, 8'h8F);
    push(0, 7'h12, 8'h00, 0, 200, 0, "R6");
    push(0, 7'h12, 8'h00, 0, 1, 0, "R6");
    push(1, 7'h01, 8'h80, 0, 0, 0, "R6");
    // period 3: receive window closes, mark 2002
    cur_pwr = 5'd0;
    push_tx(800, 8'h80);
    push(0, 7'h12, 8'h08, 0, 0, 0, "R5");
    push_rx();
    push(0, 7'h12, 8'h00, 0, 700, 0, "R9");
    push(0, 7'h12, 8'h00, 0, 1, 0, "R9");
    push(1, 7'h01, 8'h80, 0, 0, 0, "R9");
    // period 4: CRC failure, mark 3003
    cur_pwr = 5'd15;
    push_tx(300, 8'h8F);
    push(0, 7'h12, 8'h08, 0, 0, 0, "R5");
    push_rx();
    push(0, 7'h12, 8'h20, 0, 0, 0, "R11");
    push(0, 7'h12, 8'h60, 0, 3, 2, "R8");
    push(1, 7'h01, 8'h80, 0, 0, 0, "R8");
  endtask

  task automatic tick_once(inout bit seen_valid, inout bit unstable,
                           input logic [15:0] ref_cmd);
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
    if (cmd_valid) seen_valid = 1;
    if ({cmd_write, cmd_addr, cmd_wdata} != ref_cmd) unstable = 1;
    @(negedge clk);
    if (cmd_valid) seen_valid = 1;
    if ({cmd_write, cmd_addr, cmd_wdata} != ref_cmd) unstable = 1;
  endtask

  // monitor: pops expectations and compares as the design issues commands
  task automatic run_scoreboard();
    while (expq.size() > 0) begin
      exp_t  it;
      string tg;
      bit    sv, us;
      it = expq.pop_front();
      tg = tagq.pop_front();
      tx_power = it.pwr;
      if (it.pre > 0) begin
        sv = 0; us = 0;
        for (int i = 1; i < int'(it.pre); i++) tick_once(sv, us, {cmd_write, cmd_addr, cmd_wdata});
        repeat (5) begin
          @(negedge clk);
          if (cmd_valid) sv = 1;
        end
        chk(!sv, "R10", "command before period elapsed", 32'(sv), 0);
        tick_once(sv, us, {cmd_write, cmd_addr, cmd_wdata});
      end
      while (!cmd_valid) @(negedge clk);
      chk(cmd_write == it.wr, tg, "cmd_write", 32'(cmd_write), 32'(it.wr));
      chk(cmd_addr == it.addr, tg, "cmd_addr", 32'(cmd_addr), 32'(it.addr));
      if (it.wr)
        chk(cmd_wdata == it.data, tg, "cmd_wdata", 32'(cmd_wdata), 32'(it.data));
      if (it.adv > 0) begin
        logic [15:0] held;
        held = {cmd_write, cmd_addr, cmd_wdata};
        sv = 0; us = 0;
        for (int i = 0; i < int'(it.adv); i++) tick_once(sv, us, held);
        chk(!us && cmd_valid, "R4", "command held while pending", 32'(us), 0);
      end
      cmd_rdata = it.wr ? 8'h00 : it.data;
      cmd_done  = 1'b1;
      @(negedge clk);
      cmd_done  = 1'b0;
      chk(!cmd_valid, "R4", "valid after done", 32'(cmd_valid), 0);
      chk(evt_reply == (it.evt == 2'd1), tg, "evt_reply", 32'(evt_reply), 32'(it.evt == 2'd1));
      chk(evt_crc_err == (it.evt == 2'd2), tg, "evt_crc_err", 32'(evt_crc_err), 32'(it.evt == 2'd2));
    end
  endtask

  initial begin
    rst_n = 1'b0; ms_tick = 1'b0; cmd_done = 1'b0; cmd_rdata = 8'h00; tx_power = 5'd9;
    build();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!cmd_valid && !evt_reply && !evt_crc_err, "R1", "outputs in reset",
        {29'd0, cmd_valid, evt_reply, evt_crc_err}, 0);
    rst_n = 1'b1;
    run_scoreboard();
    begin
      bit sv;
      sv = 0;
      repeat (40) begin
        @(negedge clk);
        if (cmd_valid) sv = 1;
      end
      chk(!sv, "R10", "idle after final sleep", 32'(sv), 0);
    end
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule